// File: doc/BRIEF.md
# Reservation Station Issue and Wakeup Scheduler

This block is the issue and wakeup core of an out-of-order floating-point scheduler built on reservation stations and register renaming. Instructions arrive one at a time, in program order, on an issue port. Each one takes the lowest-numbered free station. Each source operand is either copied from the architectural register file or replaced by the tag of the station that will produce it. The destination register is then renamed to the new station's tag, so later readers wait for this station and not for an older writer.

Results come back on a common result bus that carries a tag and a value. Every waiting station whose source tag matches the bus picks up the value. Every register still owned by that tag takes the value and drops its tag. The station that produced the result is released. When both operands of a station are present, it is ready. The lowest-indexed ready station is sent to the functional-unit request port, one per cycle. The functional units are outside this block.

Tags are station index plus one, and tag 0 means "value present". The defaults are 8 stations, 16 registers, 32-bit data and 4-bit opcodes. After reset, register r holds the value r.

Top module: `rs_sched`

## Requirements
- R1: After reset, every station is free: issue_ready is 1, issue_tag is 1 and fu_valid is 0. Every register r reads rd_val = r and rd_tag = 0.
- R2: issue_tag always shows the tag (index + 1) of the lowest free station. issue_ready is 0 exactly when all stations are busy. An issue_valid offered while issue_ready is 0 changes no station and no register tag.
- R3: A source whose register tag is 0 at issue captures that register's value. This value later appears on fu_a (first source) or fu_b (second source).
- R4: A source whose register tag is nonzero at issue keeps that tag. The station is not dispatched until a bus broadcast with that tag delivers the value.
- R5: The cycle after an accepted issue, rd_tag for the destination register equals the tag that was shown on issue_tag.
- R6: A bus broadcast writes cdb_value into a register and clears its tag only if the register's tag equals cdb_tag. A register owned by another tag keeps both its value and its tag.
- R7: If a source's producer broadcasts in the same cycle as the consumer issues, the broadcast value is captured at issue. The consumer is ready in the next cycle.
- R8: When any station is ready, fu_valid is 1. fu_tag, fu_op, fu_a and fu_b then belong to the lowest-indexed ready station. At most one station is dispatched per cycle.
- R9: A busy station is released by a bus broadcast of its own tag. It can be allocated again from the next cycle.
- R10: A dispatched station is never dispatched again while it stays busy.
- R11: If an issue renames register d in the same cycle as a broadcast clears d's previous owner, the new issue tag wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Instruction offered at the head of the in-order queue |
| issue_op | input | 4 | Operation code |
| issue_dst | input | 4 | Destination register |
| issue_src1 | input | 4 | First source register |
| issue_src2 | input | 4 | Second source register |
| issue_ready | output | 1 | A station is free; an offered instruction is accepted |
| issue_tag | output | 4 | Tag the next accepted instruction receives |
| cdb_valid | input | 1 | Result bus broadcast this cycle |
| cdb_tag | input | 4 | Tag of the producing station |
| cdb_value | input | 32 | Result value |
| fu_valid | output | 1 | A ready station is being dispatched |
| fu_tag | output | 4 | Tag of the dispatched station |
| fu_op | output | 4 | Operation of the dispatched station |
| fu_a | output | 32 | First operand value |
| fu_b | output | 32 | Second operand value |
| rd_idx | input | 4 | Architectural register to observe |
| rd_val | output | 32 | Value of register rd_idx |
| rd_tag | output | 4 | Producer tag of register rd_idx (0 = current) |

## Verification
Issue and result write-back can act on the same state in one cycle. A new instruction may read a source whose producer is broadcasting right then. It may also rename a register whose old owner is being cleared right then. Directed sequences set up both collisions: the bench issues the consumer, or a second writer of the same register, in the exact cycle its predecessor's tag is driven on the bus. A cycle-level reference model in the bench decides the outcome: the bypassed operand must reach fu_a, and the register must show the newer tag. Long random runs with a few registers and a random result-return stub make these collisions happen many more times.

// File: rtl/rs_sched_pkg.sv
package rs_sched_pkg;
    localparam int unsigned DEF_STATIONS = 8;
    localparam int unsigned DEF_REGS     = 16;
    localparam int unsigned DEF_DATA_W   = 32;
    localparam int unsigned DEF_OP_W     = 4;

    // width of a producer tag: station index + 1, zero reserved
    function automatic int unsigned tag_width(input int unsigned n);
        return $clog2(n + 1);
    endfunction
endpackage

// File: rtl/rs_pick_lowest.sv
module rs_pick_lowest #(
    parameter int unsigned N = 8,
    localparam int unsigned W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0] req,
    output logic         found,
    output logic [W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = W'(i);
            end
        end
    end
endmodule

// File: rtl/rs_reg_table.sv
module rs_reg_table #(
    parameter int unsigned NUM_REGS = 16,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned TAG_W    = 4,
    localparam int unsigned REG_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_W-1:0]  src1_idx,
    input  logic [REG_W-1:0]  src2_idx,
    output logic [DATA_W-1:0] src1_val,
    output logic [TAG_W-1:0]  src1_tag,
    output logic [DATA_W-1:0] src2_val,
    output logic [TAG_W-1:0]  src2_tag,
    input  logic [REG_W-1:0]  obs_idx,
    output logic [DATA_W-1:0] obs_val,
    output logic [TAG_W-1:0]  obs_tag,
    input  logic              wb_valid,
    input  logic [TAG_W-1:0]  wb_tag,
    input  logic [DATA_W-1:0] wb_value,
    input  logic              rename_en,
    input  logic [REG_W-1:0]  rename_idx,
    input  logic [TAG_W-1:0]  rename_tag
);
    typedef struct packed {
        logic [NUM_REGS-1:0][DATA_W-1:0] val;
        logic [NUM_REGS-1:0][TAG_W-1:0]  tag;
    } table_t;

    table_t tbl_q, tbl_d;

    always_comb begin
        tbl_d = tbl_q;
        for (int r = 0; r < NUM_REGS; r++) begin
            // write-back only while the register still names this producer
            if (wb_valid && (tbl_q.tag[r] != '0) && (tbl_q.tag[r] == wb_tag)) begin
                tbl_d.val[r] = wb_value;
                tbl_d.tag[r] = '0;
            end
            // a rename issued in the same cycle takes ownership last
            if (rename_en && (rename_idx == REG_W'(r))) begin
                tbl_d.tag[r] = rename_tag;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NUM_REGS; r++) begin
                tbl_q.val[r] <= DATA_W'(r);
                tbl_q.tag[r] <= '0;
            end
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign src1_val = tbl_q.val[src1_idx];
    assign src1_tag = tbl_q.tag[src1_idx];
    assign src2_val = tbl_q.val[src2_idx];
    assign src2_tag = tbl_q.tag[src2_idx];
    assign obs_val  = tbl_q.val[obs_idx];
    assign obs_tag  = tbl_q.tag[obs_idx];
endmodule

// File: rtl/rs_station_pool.sv
module rs_station_pool #(
    parameter int unsigned NUM_RS = 8,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned OP_W   = 4,
    parameter int unsigned TAG_W  = 4,
    localparam int unsigned SEL_W = $clog2(NUM_RS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_en,
    input  logic [SEL_W-1:0]  alloc_idx,
    input  logic [OP_W-1:0]   alloc_op,
    input  logic [DATA_W-1:0] alloc_vj,
    input  logic [TAG_W-1:0]  alloc_qj,
    input  logic [DATA_W-1:0] alloc_vk,
    input  logic [TAG_W-1:0]  alloc_qk,
    input  logic              bus_valid,
    input  logic [TAG_W-1:0]  bus_tag,
    input  logic [DATA_W-1:0] bus_value,
    input  logic              disp_en,
    input  logic [SEL_W-1:0]  disp_idx,
    output logic [NUM_RS-1:0] busy_vec,
    output logic [NUM_RS-1:0] ready_vec,
    output logic [OP_W-1:0]   disp_op,
    output logic [DATA_W-1:0] disp_a,
    output logic [DATA_W-1:0] disp_b
);
    typedef struct packed {
        logic              busy;
        logic              sent;
        logic [OP_W-1:0]   op;
        logic [DATA_W-1:0] vj;
        logic [DATA_W-1:0] vk;
        logic [TAG_W-1:0]  qj;
        logic [TAG_W-1:0]  qk;
    } slot_t;

    slot_t [NUM_RS-1:0] slot_q, slot_d;

    always_comb begin
        slot_d = slot_q;
        for (int i = 0; i < NUM_RS; i++) begin
            // own result on the bus releases the station
            if (bus_valid && slot_q[i].busy && (bus_tag == TAG_W'(i + 1))) begin
                slot_d[i].busy = 1'b0;
                slot_d[i].sent = 1'b0;
            end
            if (disp_en && (disp_idx == SEL_W'(i))) begin
                slot_d[i].sent = 1'b1;
            end
            // operand wakeup by tag match
            if (bus_valid && (slot_q[i].qj != '0) && (slot_q[i].qj == bus_tag)) begin
                slot_d[i].vj = bus_value;
                slot_d[i].qj = '0;
            end
            if (bus_valid && (slot_q[i].qk != '0) && (slot_q[i].qk == bus_tag)) begin
                slot_d[i].vk = bus_value;
                slot_d[i].qk = '0;
            end
            if (alloc_en && (alloc_idx == SEL_W'(i))) begin
                slot_d[i].busy = 1'b1;
                slot_d[i].sent = 1'b0;
                slot_d[i].op   = alloc_op;
                slot_d[i].vj   = alloc_vj;
                slot_d[i].qj   = alloc_qj;
                slot_d[i].vk   = alloc_vk;
                slot_d[i].qk   = alloc_qk;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    for (genvar g = 0; g < NUM_RS; g++) begin : g_flags
        assign busy_vec[g]  = slot_q[g].busy;
        assign ready_vec[g] = slot_q[g].busy && !slot_q[g].sent
                              && (slot_q[g].qj == '0) && (slot_q[g].qk == '0);
    end

    assign disp_op = slot_q[disp_idx].op;
    assign disp_a  = slot_q[disp_idx].vj;
    assign disp_b  = slot_q[disp_idx].vk;
endmodule

// File: rtl/rs_sched.sv
module rs_sched
    import rs_sched_pkg::*;
#(
    parameter int unsigned NUM_RS   = DEF_STATIONS,
    parameter int unsigned NUM_REGS = DEF_REGS,
    parameter int unsigned DATA_W   = DEF_DATA_W,
    parameter int unsigned OP_W     = DEF_OP_W,
    localparam int unsigned SEL_W   = $clog2(NUM_RS),
    localparam int unsigned REG_W   = $clog2(NUM_REGS),
    localparam int unsigned TAG_W   = tag_width(NUM_RS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_valid,
    input  logic [OP_W-1:0]   issue_op,
    input  logic [REG_W-1:0]  issue_dst,
    input  logic [REG_W-1:0]  issue_src1,
    input  logic [REG_W-1:0]  issue_src2,
    output logic              issue_ready,
    output logic [TAG_W-1:0]  issue_tag,
    input  logic              cdb_valid,
    input  logic [TAG_W-1:0]  cdb_tag,
    input  logic [DATA_W-1:0] cdb_value,
    output logic              fu_valid,
    output logic [TAG_W-1:0]  fu_tag,
    output logic [OP_W-1:0]   fu_op,
    output logic [DATA_W-1:0] fu_a,
    output logic [DATA_W-1:0] fu_b,
    input  logic [REG_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_val,
    output logic [TAG_W-1:0]  rd_tag
);
    typedef struct packed {
        logic [DATA_W-1:0] v;
        logic [TAG_W-1:0]  q;
    } opnd_t;

    logic [NUM_RS-1:0] busy_vec, ready_vec;
    logic              free_found, rdy_found, issue_fire;
    logic [SEL_W-1:0]  free_idx, rdy_idx;
    logic [DATA_W-1:0] s1_val, s2_val;
    logic [TAG_W-1:0]  s1_tag, s2_tag;
    opnd_t             opj, opk;

    rs_pick_lowest #(.N(NUM_RS)) u_pick_free (
        .req(~busy_vec), .found(free_found), .idx(free_idx)
    );

    rs_pick_lowest #(.N(NUM_RS)) u_pick_ready (
        .req(ready_vec), .found(rdy_found), .idx(rdy_idx)
    );

    assign issue_ready = free_found;
    assign issue_tag   = TAG_W'(free_idx) + TAG_W'(1);
    assign issue_fire  = issue_valid && free_found;

    // operand source: register value, same-cycle bus bypass, or producer tag
    function automatic opnd_t resolve(input logic [DATA_W-1:0] rv,
                                      input logic [TAG_W-1:0]  rq);
        opnd_t o;
        if (rq == '0) begin
            o.v = rv;
            o.q = '0;
        end else if (cdb_valid && (cdb_tag == rq)) begin
            o.v = cdb_value;
            o.q = '0;
        end else begin
            o.v = rv;
            o.q = rq;
        end
        return o;
    endfunction

    always_comb begin
        opj = resolve(s1_val, s1_tag);
        opk = resolve(s2_val, s2_tag);
    end

    rs_reg_table #(
        .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .TAG_W(TAG_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .src1_idx   (issue_src1),
        .src2_idx   (issue_src2),
        .src1_val   (s1_val),
        .src1_tag   (s1_tag),
        .src2_val   (s2_val),
        .src2_tag   (s2_tag),
        .obs_idx    (rd_idx),
        .obs_val    (rd_val),
        .obs_tag    (rd_tag),
        .wb_valid   (cdb_valid),
        .wb_tag     (cdb_tag),
        .wb_value   (cdb_value),
        .rename_en  (issue_fire),
        .rename_idx (issue_dst),
        .rename_tag (issue_tag)
    );

    rs_station_pool #(
        .NUM_RS(NUM_RS), .DATA_W(DATA_W), .OP_W(OP_W), .TAG_W(TAG_W)
    ) u_pool (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc_en  (issue_fire),
        .alloc_idx (free_idx),
        .alloc_op  (issue_op),
        .alloc_vj  (opj.v),
        .alloc_qj  (opj.q),
        .alloc_vk  (opk.v),
        .alloc_qk  (opk.q),
        .bus_valid (cdb_valid),
        .bus_tag   (cdb_tag),
        .bus_value (cdb_value),
        .disp_en   (rdy_found),
        .disp_idx  (rdy_idx),
        .busy_vec  (busy_vec),
        .ready_vec (ready_vec),
        .disp_op   (fu_op),
        .disp_a    (fu_a),
        .disp_b    (fu_b)
    );

    assign fu_valid = rdy_found;
    assign fu_tag   = TAG_W'(rdy_idx) + TAG_W'(1);
endmodule

// File: rtl/rs_sched_checker.sv
module rs_sched_checker #(
    parameter int unsigned NUM_RS = 8,
    parameter int unsigned REG_W  = 4,
    parameter int unsigned TAG_W  = 4,
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              issue_valid,
    input logic              issue_ready,
    input logic [TAG_W-1:0]  issue_tag,
    input logic [REG_W-1:0]  issue_dst,
    input logic              cdb_valid,
    input logic [TAG_W-1:0]  cdb_tag,
    input logic [DATA_W-1:0] cdb_value,
    input logic              fu_valid,
    input logic [TAG_W-1:0]  fu_tag,
    input logic [REG_W-1:0]  rd_idx,
    input logic [DATA_W-1:0] rd_val,
    input logic [TAG_W-1:0]  rd_tag
);
    AST_ISSUE_TAG_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        issue_ready |-> (issue_tag != '0) && (issue_tag <= TAG_W'(NUM_RS))); // R2

    AST_FU_TAG_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        fu_valid |-> (fu_tag != '0) && (fu_tag <= TAG_W'(NUM_RS))); // R8

    AST_NO_REDISPATCH: assert property (@(posedge clk) disable iff (!rst_n)
        fu_valid |=> !(fu_valid && (fu_tag == $past(fu_tag)))); // R10

    AST_RENAME_OWNS: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && issue_ready && (rd_idx == issue_dst))
        |=> ((rd_idx != $past(rd_idx)) || (rd_tag == $past(issue_tag)))); // R5

    AST_WRITEBACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (cdb_valid && (rd_tag != '0) && (rd_tag == cdb_tag)
         && !(issue_valid && issue_ready && (issue_dst == rd_idx)))
        |=> ((rd_idx != $past(rd_idx))
             || ((rd_tag == '0) && (rd_val == $past(cdb_value))))); // R6
endmodule

bind rs_sched rs_sched_checker #(
    .NUM_RS(NUM_RS), .REG_W(REG_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_valid (issue_valid),
    .issue_ready (issue_ready),
    .issue_tag   (issue_tag),
    .issue_dst   (issue_dst),
    .cdb_valid   (cdb_valid),
    .cdb_tag     (cdb_tag),
    .cdb_value   (cdb_value),
    .fu_valid    (fu_valid),
    .fu_tag      (fu_tag),
    .rd_idx      (rd_idx),
    .rd_val      (rd_val),
    .rd_tag      (rd_tag)
);

// File: tb/rs_sched_tb.sv
module rs_sched_tb;
    localparam int NRS = 8;
    localparam int NREG = 16;
    localparam int DW = 32;
    localparam int OW = 4;
    localparam int TW = 4;
    localparam int RW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          issue_valid = 1'b0;
    logic [OW-1:0] issue_op = '0;
    logic [RW-1:0] issue_dst = '0, issue_src1 = '0, issue_src2 = '0;
    logic          issue_ready;
    logic [TW-1:0] issue_tag;
    logic          cdb_valid = 1'b0;
    logic [TW-1:0] cdb_tag = '0;
    logic [DW-1:0] cdb_value = '0;
    logic          fu_valid;
    logic [TW-1:0] fu_tag;
    logic [OW-1:0] fu_op;
    logic [DW-1:0] fu_a, fu_b;
    logic [RW-1:0] rd_idx = '0;
    logic [DW-1:0] rd_val;
    logic [TW-1:0] rd_tag;

    rs_sched u_dut (.*);

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;

    // reference state
    bit            m_busy[NRS], m_sent[NRS];
    int            m_op[NRS], m_qj[NRS], m_qk[NRS];
    logic [DW-1:0] m_vj[NRS], m_vk[NRS];
    logic [DW-1:0] m_rv[NREG];
    int            m_rq[NREG];

    bit            n_busy[NRS], n_sent[NRS];
    int            n_op[NRS], n_qj[NRS], n_qk[NRS];
    logic [DW-1:0] n_vj[NRS], n_vk[NRS];
    logic [DW-1:0] n_rv[NREG];
    int            n_rq[NREG];

    function automatic logic [DW-1:0] fu_res(int op, logic [DW-1:0] a, logic [DW-1:0] b);
        return (a * 3) + (b ^ DW'(op));
    endfunction

    function automatic int lowest_free();
        for (int i = 0; i < NRS; i++) if (!m_busy[i]) return i;
        return -1;
    endfunction

    function automatic int lowest_ready();
        for (int i = 0; i < NRS; i++)
            if (m_busy[i] && !m_sent[i] && m_qj[i] == 0 && m_qk[i] == 0) return i;
        return -1;
    endfunction

    function automatic int pick_sent(bit rnd);
        int lst[NRS];
        int n = 0;
        for (int i = 0; i < NRS; i++)
            if (m_busy[i] && m_sent[i]) begin lst[n] = i; n++; end
        if (n == 0) return -1;
        return rnd ? lst[$urandom % n] : lst[0];
    endfunction

    task automatic chk(string rq, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic compare(string ph);
        int f = lowest_free();
        int r = lowest_ready();
        chk({ph, " R2"}, "issue_ready", DW'(issue_ready), DW'(f >= 0));
        if (f >= 0) chk({ph, " R2"}, "issue_tag", DW'(issue_tag), DW'(f + 1));
        chk({ph, " R8"}, "fu_valid", DW'(fu_valid), DW'(r >= 0));
        if (r >= 0) begin
            chk({ph, " R8"}, "fu_tag", DW'(fu_tag), DW'(r + 1));
            chk({ph, " R8"}, "fu_op", DW'(fu_op), DW'(m_op[r]));
            chk({ph, " R3"}, "fu_a", fu_a, m_vj[r]);
            chk({ph, " R3"}, "fu_b", fu_b, m_vk[r]);
        end
        chk({ph, " R5"}, "rd_tag", DW'(rd_tag), DW'(m_rq[rd_idx]));
        chk({ph, " R6"}, "rd_val", rd_val, m_rv[rd_idx]);
    endtask

    task automatic resolve(int s, output logic [DW-1:0] v, output int q);
        if (m_rq[s] == 0) begin v = m_rv[s]; q = 0; end
        else if (cdb_valid && m_rq[s] == int'(cdb_tag)) begin v = cdb_value; q = 0; end
        else begin v = '0; q = m_rq[s]; end
    endtask

    // compare at mid-low phase, advance the reference across one edge
    task automatic step(string ph);
        int f, r;
        bit fire;
        #1;
        compare(ph);
        f = lowest_free();
        r = lowest_ready();
        fire = issue_valid && (f >= 0);
        n_busy = m_busy; n_sent = m_sent; n_op = m_op;
        n_qj = m_qj; n_qk = m_qk; n_vj = m_vj; n_vk = m_vk;
        n_rv = m_rv; n_rq = m_rq;
        for (int i = 0; i < NRS; i++) begin
            if (cdb_valid && m_busy[i] && int'(cdb_tag) == i + 1) begin
                n_busy[i] = 0; n_sent[i] = 0;
            end
            if (r == i) n_sent[i] = 1;
            if (cdb_valid && m_qj[i] != 0 && m_qj[i] == int'(cdb_tag)) begin
                n_vj[i] = cdb_value; n_qj[i] = 0;
            end
            if (cdb_valid && m_qk[i] != 0 && m_qk[i] == int'(cdb_tag)) begin
                n_vk[i] = cdb_value; n_qk[i] = 0;
            end
        end
        if (fire) begin
            n_busy[f] = 1; n_sent[f] = 0; n_op[f] = int'(issue_op);
            resolve(int'(issue_src1), n_vj[f], n_qj[f]);
            resolve(int'(issue_src2), n_vk[f], n_qk[f]);
        end
        for (int g = 0; g < NREG; g++)
            if (cdb_valid && m_rq[g] != 0 && m_rq[g] == int'(cdb_tag)) begin
                n_rv[g] = cdb_value; n_rq[g] = 0;
            end
        if (fire) n_rq[issue_dst] = f + 1;
        @(posedge clk);
        m_busy = n_busy; m_sent = n_sent; m_op = n_op;
        m_qj = n_qj; m_qk = n_qk; m_vj = n_vj; m_vk = n_vk;
        m_rv = n_rv; m_rq = n_rq;
        @(negedge clk);
    endtask

    task automatic set_idle();
        issue_valid = 1'b0;
        cdb_valid = 1'b0;
    endtask

    task automatic set_issue(int op, int dst, int s1, int s2);
        issue_valid = 1'b1;
        issue_op = OW'(op);
        issue_dst = RW'(dst);
        issue_src1 = RW'(s1);
        issue_src2 = RW'(s2);
    endtask

    task automatic set_bcast(int i);
        cdb_valid = 1'b1;
        cdb_tag = TW'(i + 1);
        cdb_value = fu_res(m_op[i], m_vj[i], m_vk[i]);
    endtask

    task automatic drain(string ph);
        for (int k = 0; k < 400; k++) begin
            int s;
            bit any = 0;
            for (int i = 0; i < NRS; i++) any |= m_busy[i];
            if (!any) break;
            set_idle();
            s = pick_sent(0);
            if (s >= 0) set_bcast(s);
            step(ph);
        end
        set_idle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int a_idx, x_idx, y_idx, s;
        void'($urandom(32'd2024));
        for (int i = 0; i < NRS; i++) begin
            m_busy[i] = 0; m_sent[i] = 0; m_op[i] = 0;
            m_qj[i] = 0; m_qk[i] = 0; m_vj[i] = '0; m_vk[i] = '0;
        end
        for (int g = 0; g < NREG; g++) begin m_rv[g] = DW'(g); m_rq[g] = 0; end
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state, every register
        for (int g = 0; g < NREG; g++) begin
            rd_idx = RW'(g);
            #1;
            chk("R1", "rd_val", rd_val, DW'(g));
            chk("R1", "rd_tag", DW'(rd_tag), '0);
            chk("R1", "issue_ready", DW'(issue_ready), 1);
            chk("R1", "issue_tag", DW'(issue_tag), 1);
            chk("R1", "fu_valid", DW'(fu_valid), 0);
            @(negedge clk);
        end

        // R7: consumer issues while its producer broadcasts
        a_idx = lowest_free();
        set_issue(1, 1, 2, 3); rd_idx = 1; step("R7");
        set_idle(); step("R7");
        set_issue(2, 5, 1, 4); set_bcast(a_idx); step("R7");
        set_idle(); rd_idx = 5; step("R7");
        drain("R7");

        // R11: second writer renames while first writer clears the register
        x_idx = lowest_free();
        set_issue(3, 6, 7, 8); rd_idx = 6; step("R11");
        set_idle(); step("R11");
        y_idx = lowest_free();
        set_issue(4, 6, 9, 10); set_bcast(x_idx); step("R11");
        set_idle(); step("R11");
        chk("R11", "rd_tag", DW'(rd_tag), DW'(y_idx + 1));
        drain("R11");

        // R4 chain, R2 stall, R9 reuse
        for (int k = 0; k < NRS; k++) begin
            set_issue(k, 11, 11, 12); rd_idx = 11; step("R4");
        end
        set_issue(9, 15, 0, 0); rd_idx = 15; step("R2");
        set_idle(); step("R2");
        chk("R2", "rd_tag", DW'(rd_tag), '0);
        s = pick_sent(0);
        set_issue(9, 15, 0, 0); set_bcast(s); step("R9");
        cdb_valid = 1'b0;
        chk("R9", "issue_tag", DW'(issue_tag), DW'(s + 1));
        step("R9");
        set_idle(); step("R9");
        chk("R9", "rd_tag", DW'(rd_tag), DW'(s + 1));
        drain("R4");

        // random mix: R3 R5 R6 R8 R10
        for (int c = 0; c < 4000; c++) begin
            set_idle();
            if (($urandom % 4) != 0)
                set_issue($urandom % 16, $urandom % 6, $urandom % 6, $urandom % 6);
            if (($urandom % 2) != 0) begin
                s = pick_sent(1);
                if (s >= 0) set_bcast(s);
            end
            rd_idx = RW'($urandom % 6);
            step("rand");
        end
        drain("rand");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule